// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Logic

This unit sits on the device side of a serial NOR flash. It sees the byte stream of each chip-select frame after deserialisation. It treats the first byte of a frame as the command. From the commands it maintains the status register, which holds the write-enable latch, a 4-bit protect code, a top/bottom selector and a status-write-disable bit.

The array controller asks this unit whether a program or erase may touch a given 64 KiB sector. It raises `chk_req` with the sector number and gets `chk_ok` one cycle later. A bulk erase is launched by a `bulk_go` pulse that the unit issues when the frame closes. Read-type commands get their reply bytes on `tx_byte`, one per incoming byte slot. The hardware write-protect pin `wp_n` and the status-write-disable bit together can freeze the status register.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset the status byte is 0x00. Opcode 0x06 sets status bit 1 (write-enable latch) and opcode 0x04 clears it. Both take effect at the clock edge that takes the opcode byte. Status bit 0 always reads 0.
- R2: In a frame opened with 0x05, every byte slot after the opcode returns the current status byte on `tx_byte`, registered at the edge that takes that slot's input byte. The opcode slot returns 0x00.
- R3: In a frame opened with 0x01, the second byte loads status bits [7:2] only when the write-enable latch is set. Otherwise the status register keeps its value.
- R4: When status bit 7 is 1 and `wp_n` is 0, a 0x01 frame leaves the status register unchanged. With any other combination of bit 7 and `wp_n`, the write proceeds under R3.
- R5: The protect code n is {status[6], status[4], status[3], status[2]}. The number of protected sectors is 0 for n = 0, and 2^(n-1) otherwise, limited to the whole array (512 sectors by default). With status bit 5 = 0, that many sectors are protected starting from the highest sector and counting down.
- R6: With status bit 5 = 1, the protected sectors start at sector 0 and run upward.
- R7: One cycle after `chk_req`, `chk_ok` is 1 only if all of the following hold: the current frame's opcode is 0x02 (page program) or 0xD8 (sector erase), the latch is set, and `chk_sector` is not protected. Otherwise `chk_ok` is 0.
- R8: One cycle after `cs_end` of a frame opened with 0xC7, `bulk_go` pulses for one cycle if the latch is set and the protect code is 0. If any sector is protected, or the latch is clear, it stays 0.
- R9: At the end of a frame that ran 0x02, 0xD8 or 0xC7, or that delivered the data byte of a 0x01 write, the write-enable latch is cleared.
- R10: In a frame opened with 0x9F, slots 1, 2 and 3 return the identifier bytes, most significant first (0x20, 0xBA, 0x19 by default). Later slots return 0x00.
- R11: Opcode 0xB7 sets `wide_addr`. A frame of 0x99 that directly follows a frame of 0x66 clears `wide_addr` and the latch and keeps status bits [7:2].
- R12: A 0x99 frame not directly preceded by a 0x66 frame changes neither the latch nor `wide_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_start | input | 1 | Pulse: chip select asserted, new frame |
| cs_end | input | 1 | Pulse: chip select released, frame over |
| rx_vld | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| chk_req | input | 1 | Permission request for a program or erase |
| chk_sector | input | ADDR_W-SEC_LOG (9) | Sector index of the request |
| tx_byte | output | 8 | Reply byte for the latest slot |
| status | output | 8 | Live status register |
| wide_addr | output | 1 | 4-byte addressing selected |
| chk_ok | output | 1 | Request granted (one cycle after chk_req) |
| bulk_go | output | 1 | One-cycle bulk-erase launch |

## Verification
The protect-range table exercises both ends of the array at each power-of-two boundary, in both directions. It also drives codes at and beyond the full-array limit. An off-by-one in the count would move the boundary sector, and a missing cap would wrap the count to zero and protect nothing. The status lock is driven through all four combinations of the disable bit and the pin. A reversed pin polarity would let the 0x00 write through while the lock is set. Directed frames check that the latch drops only after completing frames, that a protected array refuses bulk erase, and that 0x99 resets only when 0x66 came in the frame just before it.

// File: rtl/flash_wp_unit.sv
module flash_wp_unit #(
  parameter int          ADDR_W  = 25,
  parameter int          SEC_LOG = 16,
  parameter logic [23:0] DEV_ID  = 24'h20BA19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_start,
  input  logic                      cs_end,
  input  logic                      rx_vld,
  input  logic [7:0]                rx_byte,
  input  logic                      wp_n,
  input  logic                      chk_req,
  input  logic [ADDR_W-SEC_LOG-1:0] chk_sector,
  output logic [7:0]                tx_byte,
  output logic [7:0]                status,
  output logic                      wide_addr,
  output logic                      chk_ok,
  output logic                      bulk_go
);
  localparam int SW = ADDR_W - SEC_LOG;
  localparam logic [SW:0] NSEC_V = (SW+1)'(1) << SW;

  localparam logic [7:0] OP_WRSR = 8'h01, OP_PROG = 8'h02, OP_WRDI = 8'h04,
                         OP_RDSR = 8'h05, OP_WREN = 8'h06, OP_RSTE = 8'h66,
                         OP_RSTM = 8'h99, OP_IDRD = 8'h9F, OP_WIDE = 8'hB7,
                         OP_BULK = 8'hC7, OP_SERA = 8'hD8;

  logic [5:0] nv;
  logic       wel, have_cmd, done, arm;
  logic [7:0] cmd;
  logic [2:0] idx;
  logic [7:0] resp;
  logic [3:0] bp_code;
  logic [SW:0] prot_cnt;
  logic        prot_hit;

  assign status  = {nv, wel, 1'b0};
  assign bp_code = {nv[4], nv[2:0]};

  always_comb begin
    if (bp_code == 4'd0)
      prot_cnt = '0;
    else if (int'(bp_code) - 1 >= SW)
      prot_cnt = NSEC_V;
    else
      prot_cnt = (SW+1)'(1) << (bp_code - 4'd1);
  end

  assign prot_hit = nv[3] ? ({1'b0, chk_sector} < prot_cnt)
                          : ({1'b0, chk_sector} >= NSEC_V - prot_cnt);

  always_comb begin
    resp = 8'h00;
    if (cmd == OP_RDSR)
      resp = status;
    else if (cmd == OP_IDRD) begin
      case (idx)
        3'd1:    resp = DEV_ID[23:16];
        3'd2:    resp = DEV_ID[15:8];
        3'd3:    resp = DEV_ID[7:0];
        default: resp = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv        <= '0;
      wel       <= 1'b0;
      have_cmd  <= 1'b0;
      done      <= 1'b0;
      arm       <= 1'b0;
      cmd       <= 8'h00;
      idx       <= '0;
      tx_byte   <= 8'h00;
      wide_addr <= 1'b0;
      chk_ok    <= 1'b0;
      bulk_go   <= 1'b0;
    end else begin
      chk_ok  <= 1'b0;
      bulk_go <= 1'b0;

      if (cs_start) begin
        have_cmd <= 1'b0;
        idx      <= '0;
        done     <= 1'b0;
      end

      if (rx_vld) begin
        if (!have_cmd) begin
          have_cmd <= 1'b1;
          cmd      <= rx_byte;
          idx      <= 3'd1;
          tx_byte  <= 8'h00;
          case (rx_byte)
            OP_WREN:                   wel       <= 1'b1;
            OP_WRDI:                   wel       <= 1'b0;
            OP_WIDE:                   wide_addr <= 1'b1;
            OP_PROG, OP_SERA, OP_BULK: done      <= 1'b1;
            default: ;
          endcase
        end else begin
          if (idx != 3'd7) idx <= idx + 3'd1;
          tx_byte <= resp;
          if (cmd == OP_WRSR && idx == 3'd1) begin
            done <= 1'b1;
            if (wel && !(nv[5] && !wp_n)) nv <= rx_byte[7:2];
          end
        end
      end

      if (chk_req)
        chk_ok <= have_cmd && (cmd == OP_PROG || cmd == OP_SERA) && wel && !prot_hit;

      if (cs_end) begin
        if (done) wel <= 1'b0;
        if (have_cmd && cmd == OP_BULK && wel && bp_code == 4'd0) bulk_go <= 1'b1;
        arm <= have_cmd && cmd == OP_RSTE;
        if (arm && have_cmd && cmd == OP_RSTM) begin
          wel       <= 1'b0;
          wide_addr <= 1'b0;
        end
        have_cmd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_wp_unit_chk.sv
module flash_wp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_vld,
  input logic [7:0] rx_byte,
  input logic       wp_n,
  input logic       have_cmd,
  input logic [7:0] cmd,
  input logic [2:0] idx,
  input logic [7:0] status,
  input logic       chk_ok,
  input logic       bulk_go
);
  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld && !have_cmd && rx_byte == 8'h04 |=> !status[1]); // R1

  AST_WREN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld && !have_cmd && rx_byte == 8'h06 |=> status[1]); // R1

  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld && have_cmd && cmd == 8'h01 && idx == 3'd1 && status[7] && !wp_n
      |=> $stable(status[7:2])); // R4

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |-> $past(status[1])); // R7

  AST_BULK_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_go |-> ($past(status[6]) == 1'b0 && $past(status[4:2]) == 3'd0)); // R8

  AST_BULK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_go |=> !bulk_go); // R8
endmodule

bind flash_wp_unit flash_wp_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte), .wp_n(wp_n),
  .have_cmd(have_cmd), .cmd(cmd), .idx(idx), .status(status),
  .chk_ok(chk_ok), .bulk_go(bulk_go)
);

// File: tb/flash_wp_unit_test.sv
`timescale 1ns/1ps
module flash_wp_unit_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_start = 0, cs_end = 0, rx_vld = 0, wp_n = 1, chk_req = 0;
  logic [7:0] rx_byte = 0;
  logic [8:0] chk_sector = 0;
  logic [7:0] tx_byte, status;
  logic       wide_addr, chk_ok, bulk_go;
  int errors = 0, total = 0, cycles = 0;

  always #2.5 clk = ~clk;

  flash_wp_unit uut (.*);

  // entry: [14:11] code, [10] bottom, [9:1] sector, [0] expected grant
  localparam logic [14:0] PTAB [18] = '{
    {4'd0, 1'b0, 9'd511, 1'b1}, {4'd1, 1'b0, 9'd511, 1'b0},
    {4'd1, 1'b0, 9'd510, 1'b1}, {4'd2, 1'b0, 9'd510, 1'b0},
    {4'd2, 1'b0, 9'd509, 1'b1}, {4'd4, 1'b0, 9'd504, 1'b0},
    {4'd4, 1'b0, 9'd503, 1'b1}, {4'd9, 1'b0, 9'd256, 1'b0},
    {4'd9, 1'b0, 9'd255, 1'b1}, {4'd10, 1'b0, 9'd0, 1'b0},
    {4'd15, 1'b0, 9'd0, 1'b0},  {4'd1, 1'b1, 9'd0, 1'b0},
    {4'd1, 1'b1, 9'd1, 1'b1},   {4'd3, 1'b1, 9'd3, 1'b0},
    {4'd3, 1'b1, 9'd4, 1'b1},   {4'd9, 1'b1, 9'd255, 1'b0},
    {4'd9, 1'b1, 9'd256, 1'b1}, {4'd12, 1'b1, 9'd511, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cs_open();
    @(negedge clk) cs_start = 1;
    @(negedge clk) cs_start = 0;
  endtask

  task automatic cs_close(output logic bg);
    @(negedge clk) cs_end = 1;
    @(negedge clk) cs_end = 0;
    bg = bulk_go;
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk) begin rx_vld = 1; rx_byte = b; end
    @(negedge clk) rx_vld = 0;
    r = tx_byte;
  endtask

  task automatic ask(input logic [8:0] s, output logic ok);
    @(negedge clk) begin chk_req = 1; chk_sector = s; end
    @(negedge clk) chk_req = 0;
    ok = chk_ok;
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; logic bg;
    cs_open(); xfer(op, r); cs_close(bg);
  endtask

  task automatic wr_sr(input logic [7:0] v, input logic with_wen);
    logic [7:0] r; logic bg;
    if (with_wen) cmd1(8'h06);
    cs_open(); xfer(8'h01, r); xfer(v, r); cs_close(bg);
  endtask

  task automatic rd_sr(output logic [7:0] v);
    logic [7:0] r; logic bg;
    cs_open(); xfer(8'h05, r); xfer(8'h00, v); cs_close(bg);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; total++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r, r2; logic ok, bg;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset status", status, 8'h00);
    check("R11 reset wide_addr", wide_addr, 0);

    // protection table
    for (int i = 0; i < 18; i++) begin
      logic [3:0] c; logic tb; logic [8:0] s; logic e;
      {c, tb, s, e} = PTAB[i];
      wr_sr({1'b0, c[3], tb, c[2:0], 2'b00}, 1'b1);
      cmd1(8'h06);
      cs_open(); xfer(8'h02, r); ask(s, ok); cs_close(bg);
      check(tb ? "R6 bottom range grant" : "R5 top range grant", ok, e);
    end
    wr_sr(8'h00, 1'b1);
    rd_sr(r);
    check("R9 latch cleared after status write", r, 8'h00);

    // R1 / R2
    cmd1(8'h06);
    cs_open(); xfer(8'h05, r); check("R2 opcode slot", r, 8'h00);
    xfer(8'h00, r); xfer(8'h00, r2); cs_close(bg);
    check("R1 latch set", r, 8'h02);
    check("R2 repeated slot", r2, 8'h02);
    cmd1(8'h04);
    rd_sr(r); check("R1 latch cleared", r, 8'h00);

    // R3 without latch
    wr_sr(8'h1C, 1'b0);
    rd_sr(r); check("R3 write ignored without latch", r, 8'h00);

    // R4 lock matrix
    wr_sr(8'h80, 1'b1); rd_sr(r); check("R4 pin high, set disable", r, 8'h80);
    wr_sr(8'h00, 1'b1); rd_sr(r); check("R4 pin high, disable set, writable", r, 8'h00);
    wp_n = 0;
    wr_sr(8'h80, 1'b1); rd_sr(r); check("R4 pin low, disable clear, writable", r, 8'h80);
    wr_sr(8'h00, 1'b1); rd_sr(r); check("R4 pin low, disable set, locked", r, 8'h80);
    wp_n = 1;
    wr_sr(8'h00, 1'b1); rd_sr(r); check("R4 unlocked again", r, 8'h00);

    // R8 / R9 bulk
    cmd1(8'h06);
    cs_open(); xfer(8'hC7, r); cs_close(bg);
    check("R8 bulk launched", bg, 1);
    rd_sr(r); check("R9 latch cleared after bulk", r, 8'h00);
    cs_open(); xfer(8'hC7, r); cs_close(bg);
    check("R8 bulk refused without latch", bg, 0);
    wr_sr(8'h04, 1'b1); cmd1(8'h06);
    cs_open(); xfer(8'hC7, r); cs_close(bg);
    check("R8 bulk refused when protected", bg, 0);
    wr_sr(8'h00, 1'b1);

    // R7 / R9 sector erase and wrong frame
    cmd1(8'h06);
    cs_open(); xfer(8'h05, r); ask(9'd7, ok); cs_close(bg);
    check("R7 no grant in status-read frame", ok, 0);
    cs_open(); xfer(8'hD8, r); ask(9'd7, ok); cs_close(bg);
    check("R7 sector erase granted", ok, 1);
    rd_sr(r); check("R9 latch cleared after sector erase", r, 8'h00);
    cs_open(); xfer(8'hD8, r); ask(9'd7, ok); cs_close(bg);
    check("R7 no grant without latch", ok, 0);

    // R10 identifier
    cs_open(); xfer(8'h9F, r);
    xfer(8'h00, r); check("R10 id byte 1", r, 8'h20);
    xfer(8'h00, r); check("R10 id byte 2", r, 8'hBA);
    xfer(8'h00, r); check("R10 id byte 3", r, 8'h19);
    xfer(8'h00, r); check("R10 after id", r, 8'h00);
    cs_close(bg);

    // R11 / R12 reset pair
    wr_sr(8'h24, 1'b1);
    cmd1(8'hB7);
    check("R11 wide address set", wide_addr, 1);
    cmd1(8'h06);
    cmd1(8'h99);
    rd_sr(r);
    check("R12 lone reset keeps latch", r, 8'h26);
    check("R12 lone reset keeps wide", wide_addr, 1);
    cmd1(8'h66); cmd1(8'h99);
    rd_sr(r);
    check("R11 reset clears latch, keeps bits", r, 8'h24);
    check("R11 reset clears wide", wide_addr, 0);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule